// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one data word per request into an asynchronous serial frame on a single output line. A frame is a low start bit, then 5 to 9 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The character size, parity mode and stop-bit count are chosen at run time through three configuration inputs. The block reads them when a frame's start bit begins, so a change made while a frame is on the line applies from the next frame.

A baud-rate tick comes from outside the block. The tick is a single-cycle pulse, one per bit period, and every bit boundary falls on a clock edge where the tick is high. The block accepts a word with the load strobe while `ready` is high. The accepted word's start bit begins on the next tick. `ready` also rises during the final stop bit. A word loaded in that bit period follows the current frame with no idle gap.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no frame is pending or in progress, `txd` is high, `busy` is low and `ready` is high.
- R2: A word loaded while `ready` is high is held. The next tick starts its frame, and `txd` is low (start bit) for exactly one tick period.
- R3: Data bits follow the start bit, least significant first, one per tick period. The count comes from `size_sel`: 000 = 5, 001 = 6, 010 = 7, 011 = 8, 111 = 9, and every other code = 8.
- R4: `par_sel` 10 selects even parity, 11 selects odd parity, and 00 or 01 selects no parity bit. When enabled, one parity bit follows the last data bit. Even parity is the XOR of the data bits sent. Odd parity is that value inverted.
- R5: After the data bits (or the parity bit), `txd` is high for one stop bit when `two_stop` is 0 and for two stop bits when it is 1.
- R6: While a frame is in progress, `ready` is high only during the last stop bit period. A load strobe while `ready` is low is ignored: it changes neither the frame on the line nor anything sent afterwards.
- R7: A word loaded during the last stop bit period begins its start bit at the tick that ends that stop bit, with no idle period between the frames.
- R8: The configuration inputs are sampled at the tick that begins the start bit. Changing them later in the frame has no effect on that frame.
- R9: `busy` is high from the cycle after a load is accepted until the line has returned to idle with no word pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per bit period |
| load | input | 1 | Request to send `data_in` |
| data_in | input | 9 | Character to send, LSB first |
| size_sel | input | 3 | Character size code |
| par_sel | input | 2 | Parity mode code |
| two_stop | input | 1 | 1 selects two stop bits |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | A frame is pending or on the line |
| ready | output | 1 | A load strobe would be accepted |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that every bit transition happens on a clock edge where it is high. They also assume that `load` is a plain request whose only effect comes from being sampled together with `ready`. The bench drives ticks by hand, one clock wide with idle clocks between them, so that every bit period can be observed on its own. It never raises `load` on a tick cycle. It scrambles the configuration inputs right after each start bit and pulses `load` during every frame's data bits, so the sampling rule and the ignore rule are exercised on every frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int CFG_NB_W = 4;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2
    } par_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    typedef struct packed {
        logic [CFG_NB_W-1:0] nbits;
        par_e                par;
        logic                two_stop;
    } frame_cfg_t;

    function automatic logic [CFG_NB_W-1:0] size_code_to_bits(input logic [2:0] code);
        logic [CFG_NB_W-1:0] n;
        case (code)
            3'b000:  n = CFG_NB_W'(5);
            3'b001:  n = CFG_NB_W'(6);
            3'b010:  n = CFG_NB_W'(7);
            3'b111:  n = CFG_NB_W'(9);
            default: n = CFG_NB_W'(8);
        endcase
        return n;
    endfunction

    function automatic par_e par_code_decode(input logic [1:0] code);
        par_e p;
        case (code)
            2'b10:   p = PAR_EVEN;
            2'b11:   p = PAR_ODD;
            default: p = PAR_NONE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sertx_cfg_decode.sv
module sertx_cfg_decode
    import sertx_pkg::*;
(
    input  logic [2:0]  size_sel,
    input  logic [1:0]  par_sel,
    input  logic        two_stop,
    output frame_cfg_t  cfg_d
);

    always_comb begin
        cfg_d.nbits    = size_code_to_bits(size_sel);
        cfg_d.par      = par_code_decode(par_sel);
        cfg_d.two_stop = two_stop;
    end

    // R3
    always_comb begin
        size_range_chk: assert (cfg_d.nbits >= CFG_NB_W'(5) && cfg_d.nbits <= CFG_NB_W'(9));
    end

endmodule

// File: rtl/sertx_datapath.sv
module sertx_datapath
    import sertx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [DATA_W-1:0] data_in,
    input  logic              start_frame,
    input  logic              shift_en,
    input  frame_cfg_t        cfg_d,
    output logic              pending,
    output frame_cfg_t        cfg_q,
    output logic              data_bit,
    output logic              par_bit
);

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] shreg_q;
    logic              pend_q;
    logic              par_q;
    logic              par_calc;

    // parity over the bits that the sampled size will actually send
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(cfg_d.nbits)) acc = acc ^ hold_q[i];
        end
        par_calc = (cfg_d.par == PAR_ODD) ? ~acc : acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            shreg_q <= '0;
            pend_q  <= 1'b0;
            par_q   <= 1'b0;
            cfg_q   <= '{nbits: CFG_NB_W'(8), par: PAR_NONE, two_stop: 1'b0};
        end else begin
            if (accept) begin
                hold_q <= data_in;
                pend_q <= 1'b1;
            end else if (start_frame) begin
                pend_q  <= 1'b0;
                shreg_q <= hold_q;
                cfg_q   <= cfg_d;
                par_q   <= par_calc;
            end else if (shift_en) begin
                shreg_q <= {1'b0, shreg_q[DATA_W-1:1]};
            end
        end
    end

    assign pending  = pend_q;
    assign data_bit = shreg_q[0];
    assign par_bit  = par_q;

    // R2
    accept_start_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(accept && start_frame));

    // R6
    held_word_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !start_frame) |=> $stable(hold_q));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start_frame |=> $stable(cfg_q));

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       pending,
    input  frame_cfg_t cfg_q,
    output logic       start_frame,
    output logic       shift_en,
    output logic       line_free,
    output tx_state_e  state
);

    tx_state_e             st_q;
    logic [CFG_NB_W-1:0]   cnt_q;
    logic                  last_data;
    logic                  last_stop;

    assign last_data   = (st_q == ST_DATA) && (cnt_q == cfg_q.nbits - CFG_NB_W'(1));
    assign last_stop   = (st_q == ST_STOP) &&
                         (cnt_q == (cfg_q.two_stop ? CFG_NB_W'(1) : CFG_NB_W'(0)));
    assign line_free   = (st_q == ST_IDLE) || last_stop;
    assign start_frame = tick && pending && line_free;
    assign shift_en    = tick && (st_q == ST_DATA);
    assign state       = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else if (tick) begin
            case (st_q)
                ST_IDLE: begin
                    if (pending) st_q <= ST_START;
                end
                ST_START: begin
                    st_q  <= ST_DATA;
                    cnt_q <= '0;
                end
                ST_DATA: begin
                    if (last_data) begin
                        cnt_q <= '0;
                        st_q  <= (cfg_q.par == PAR_NONE) ? ST_STOP : ST_PAR;
                    end else begin
                        cnt_q <= cnt_q + CFG_NB_W'(1);
                    end
                end
                ST_PAR: begin
                    st_q  <= ST_STOP;
                    cnt_q <= '0;
                end
                ST_STOP: begin
                    if (last_stop) begin
                        cnt_q <= '0;
                        st_q  <= pending ? ST_START : ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + CFG_NB_W'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R2
    start_entry_chk: assert property (@(posedge clk) disable iff (rst)
        start_frame |=> (st_q == ST_START));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA) |-> (cnt_q < cfg_q.nbits));

    // R5
    stop_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_STOP && tick && !last_stop) |=> (st_q == ST_STOP));

    // R4
    no_par_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PAR) |-> (cfg_q.par != PAR_NONE));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic [2:0]        size_sel,
    input  logic [1:0]        par_sel,
    input  logic              two_stop,
    output logic              txd,
    output logic              busy,
    output logic              ready
);

    frame_cfg_t cfg_d;
    frame_cfg_t cfg_q;
    tx_state_e  state;
    logic       pending;
    logic       start_frame;
    logic       shift_en;
    logic       line_free;
    logic       data_bit;
    logic       par_bit;
    logic       accept;

    sertx_cfg_decode u_cfg (
        .size_sel (size_sel),
        .par_sel  (par_sel),
        .two_stop (two_stop),
        .cfg_d    (cfg_d)
    );

    sertx_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .data_in     (data_in),
        .start_frame (start_frame),
        .shift_en    (shift_en),
        .cfg_d       (cfg_d),
        .pending     (pending),
        .cfg_q       (cfg_q),
        .data_bit    (data_bit),
        .par_bit     (par_bit)
    );

    sertx_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .pending     (pending),
        .cfg_q       (cfg_q),
        .start_frame (start_frame),
        .shift_en    (shift_en),
        .line_free   (line_free),
        .state       (state)
    );

    assign ready  = line_free && !pending;
    assign accept = load && ready;
    assign busy   = (state != ST_IDLE) || pending;

    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = data_bit;
            ST_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    // R6
    ready_line_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> txd);

    // R9
    busy_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && ready) |=> busy);

    // R6
    ignored_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !ready && !pending) |=> !pending || start_frame);

endmodule

// File: tb/sertx_top_bench.sv
module sertx_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       load = 1'b0;
    logic [8:0] data_in = '0;
    logic [2:0] size_sel = '0;
    logic [1:0] par_sel = '0;
    logic       two_stop = 1'b0;
    logic       txd;
    logic       busy;
    logic       ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sertx_top u_sertx_top (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load),
        .data_in  (data_in),
        .size_sel (size_sel),
        .par_sel  (par_sel),
        .two_stop (two_stop),
        .txd      (txd),
        .busy     (busy),
        .ready    (ready)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one tick edge, then sample at the following falling edge
    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    function automatic int nbits_of(input logic [2:0] code);
        case (code)
            3'b000: return 5;
            3'b001: return 6;
            3'b010: return 7;
            3'b111: return 9;
            default: return 8;
        endcase
    endfunction

    task automatic frame(input logic [8:0] d, input logic [2:0] sz, input logic [1:0] pm,
                         input logic ts, input bit preloaded, input bit chain,
                         input logic [8:0] nd, input logic [2:0] nsz, input logic [1:0] npm,
                         input logic nts);
        int  n;
        int  ns;
        logic p;
        n  = nbits_of(sz);
        ns = ts ? 2 : 1;
        p  = 1'b0;
        for (int i = 0; i < n; i++) p = p ^ d[i];
        if (pm == 2'b11) p = ~p;
        if (!preloaded) begin
            @(negedge clk);
            data_in = d; size_sel = sz; par_sel = pm; two_stop = ts; load = 1'b1;
            @(negedge clk) load = 1'b0;
            chk("R9 busy after load", busy, 1);
            chk("R2 ready low while pending", ready, 0);
            chk("R2 line idle before tick", txd, 1);
        end
        do_tick();
        chk(preloaded ? "R7 back-to-back start bit" : "R2 start bit", txd, 0);
        // R8: scramble configuration once the start bit is on the line
        size_sel = sz ^ 3'b101; par_sel = pm ^ 2'b01; two_stop = ~ts;
        do_tick();
        chk("R2 start lasts one tick", txd, d[0]);
        for (int i = 0; i < n; i++) begin
            if (i > 0) begin
                do_tick();
                chk("R3 data bit", txd, d[i]);
            end
            if (i == 0) begin
                chk("R6 ready low in data", ready, 0);
                load = 1'b1; data_in = ~d;
                @(negedge clk) load = 1'b0;
                chk("R3 data held after ignored load", txd, d[0]);
            end
        end
        if (pm[1]) begin
            do_tick();
            chk("R4 parity bit", txd, p);
        end
        for (int s = 0; s < ns; s++) begin
            do_tick();
            chk("R5 stop bit", txd, 1);
            chk("R6 ready in stop", ready, (s == ns - 1) ? 9'd1 : 9'd0);
            chk("R9 busy in stop", busy, 1);
        end
        if (chain) begin
            @(negedge clk);
            data_in = nd; size_sel = nsz; par_sel = npm; two_stop = nts; load = 1'b1;
            @(negedge clk) load = 1'b0;
            chk("R7 line still in stop", txd, 1);
        end else begin
            do_tick();
            chk("R1 idle line", txd, 1);
            chk("R9 busy clear", busy, 0);
            chk("R1 ready idle", ready, 1);
            do_tick();
            chk("R6 ignored load sent nothing", txd, 1);
        end
    endtask

    function automatic logic [8:0] g_data(input int g);
        return 9'((g * 73 + 45) % 512);
    endfunction

    initial begin
        bit prev_chain;
        prev_chain = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset txd", txd, 1);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset ready", ready, 1);
        do_tick();
        chk("R1 idle tick no frame", txd, 1);
        for (int g = 0; g < 128; g++) begin
            bit chain;
            int h;
            h = g + 1;
            chain = ((g % 3) != 0) && (g != 127);
            frame(g_data(g), 3'((g / 8) % 8), 2'((g / 2) % 4), 1'(g % 2), prev_chain, chain,
                  g_data(h), 3'((h / 8) % 8), 2'((h / 2) % 4), 1'(h % 2));
            prev_chain = chain;
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule